// File: doc/BRIEF.md
# NOR Flash Block Erase Sequencer

This block drives one block erase on a parallel NOR flash array built from one or more byte-wide devices that share a bus. It checks that the array is ready, issues the clear-status, erase-setup and erase-confirm commands to the chosen block, and polls for completion. When the erase ends, it reads the final status and sorts any failure into one of a few result classes. A plain erase failure makes it repeat the whole erase, up to a configured number of extra attempts.

While an erase is running, the host may ask to read the array. If the suspend capability input is set, the sequencer pauses the erase and tells the host the array is readable. When the host signals resume, the erase continues. If the capability input is clear, the read request has no effect and the host waits for the erase to end. All waits are bounded by cycle-count timeouts.

The flash bus has one address, a write-data word carrying the command byte copied to every device, a one-cycle write strobe, a read strobe and the read data. Read data is sampled in the same cycle as the read strobe.

Top module: `nfe_erase_ctrl`

## Requirements
- R1: On `erase_req` in idle, the first bus action is a write of status command 0x70. The block then reads until bit 7 is set in every device. If READY_TO+1 reads pass without that, it reports result 1 (timeout) and issues no erase command.
- R2: After ready, the block writes 0x50, then 0x20, then 0xD0. Every command byte is copied into each device lane of `fl_wdata`. `fl_addr` holds the latched block address for the whole operation.
- R3: Completion is polled on bit 7 for up to READY_TO*ERASE_MULT+1 reads. On expiry the block writes 0x70 and reports result 1.
- R4: On completion the block writes 0x70 and reads status once. If none of the error bits in mask 0x3A is set, it reports result 0 (OK).
- R5: Before any error is decoded, the block writes 0x50 and then 0x70. The status bytes of all devices are OR-merged before the decode.
- R6: The merged status decodes in this priority. Bits 0x30 both set give result 2 (bad sequence). Otherwise 0x02 gives 3 (protected). Otherwise 0x08 gives 4 (low voltage). Otherwise 0x20, or 0x10 alone, gives 5 (erase failure).
- R7: A result-5 decode caused by bit 0x20 restarts the whole erase from R1, up to MAX_RETRY times. When the retries run out, the block reports result 5. A 0x10-only failure is not retried.
- R8: While erasing with `suspend_en` high, a held `rd_req` makes the block write 0xB0 then 0x70 and poll bit 7. When the array reports ready, `suspended` goes high and the bus stays quiet. A `resume` pulse then writes 0xD0 then 0x70 and polling continues.
- R9: If the suspend poll exceeds READY_TO+1 reads, the block writes 0xD0 then 0x70 and returns to erase polling. It does not suspend again during that erase.
- R10: With `suspend_en` low, `rd_req` has no effect: no 0xB0 is written, `suspended` stays low and the erase completes normally.
- R11: After reset, `busy`, `done`, `suspended`, `fl_we` and `fl_re` are low. Each operation ends with a one-cycle `done` pulse carrying `result`, and `busy` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| erase_req | input | 1 | Start an erase (accepted in idle) |
| blk_addr | input | AW | Block address, latched on start |
| rd_req | input | 1 | Host wants to read during the erase |
| resume | input | 1 | Host finished its read, continue erase |
| suspend_en | input | 1 | Array supports erase suspend |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| result | output | 3 | 0 OK, 1 timeout, 2 bad sequence, 3 protected, 4 low voltage, 5 erase fail |
| suspended | output | 1 | Erase paused, array readable by host |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | DEVS*8 | Command byte copied per device |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | DEVS*8 | Flash read data, one status byte per device |

## Verification
The hardest path to reach from the ports is a suspend whose acknowledge never arrives. For it, the erase must still be busy when the suspend poll times out, and the host must keep `rd_req` high so that a missing re-suspend block would show up as a second 0xB0. The bench flash model can be set to ignore 0xB0 and to run a long erase. Another setting splits error bits across the two device lanes, which reaches the merge and the decode priority. The model can also fail a chosen number of erases in a row, which reaches both retry-then-success and retry exhaustion.

// File: rtl/nfe_pkg.sv
`timescale 1ns/1ps
package nfe_pkg;
    typedef enum logic [4:0] {
        S_IDLE, S_RDY_CMD, S_RDY_POLL, S_CLR, S_SETUP, S_CONFIRM, S_ERS_POLL,
        S_TO_STAT, S_SUS_CMD, S_SUS_STAT, S_SUS_POLL, S_SUSPENDED, S_RES_CMD,
        S_RES_STAT, S_FIN_STAT, S_FIN_READ, S_ERR_CLR, S_ERR_STAT, S_DONE
    } state_e;

    typedef enum logic [2:0] {
        RES_OK = 3'd0, RES_TIMEOUT = 3'd1, RES_BADSEQ = 3'd2,
        RES_PROTECT = 3'd3, RES_LOWVOLT = 3'd4, RES_FAIL = 3'd5
    } result_e;

    localparam logic [7:0] OP_STATUS = 8'h70;
    localparam logic [7:0] OP_CLEAR  = 8'h50;
    localparam logic [7:0] OP_ERASE  = 8'h20;
    localparam logic [7:0] OP_GO     = 8'hD0;
    localparam logic [7:0] OP_PAUSE  = 8'hB0;
    localparam logic [7:0] ERR_MASK  = 8'h3A;
endpackage

// File: rtl/nfe_poll_timer.sv
`timescale 1ns/1ps
module nfe_poll_timer #(
    parameter int SHORT_LIM = 16,
    parameter int MULT      = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic use_long,
    output logic expired
);
    localparam int LONG_LIM = SHORT_LIM * MULT;
    localparam int TW       = $clog2(LONG_LIM + 2);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        expired = use_long ? (cnt_q >= TW'(LONG_LIM)) : (cnt_q >= TW'(SHORT_LIM));
        if (!run)
            cnt_d = '0;
        else if (!expired)
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/nfe_stat_merge.sv
`timescale 1ns/1ps
module nfe_stat_merge #(
    parameter int DEVS = 2
) (
    input  logic [DEVS*8-1:0] raw,
    output logic [7:0]        merged,
    output logic              all_ready
);
    logic [7:0] or_chain  [DEVS+1];
    logic       and_chain [DEVS+1];

    assign or_chain[0]  = 8'h00;
    assign and_chain[0] = 1'b1;

    for (genvar g = 0; g < DEVS; g++) begin : g_lane
        assign or_chain[g+1]  = or_chain[g] | raw[g*8 +: 8];
        assign and_chain[g+1] = and_chain[g] & raw[g*8 + 7];
    end

    assign merged    = or_chain[DEVS];
    assign all_ready = and_chain[DEVS];
endmodule

// File: rtl/nfe_classify.sv
`timescale 1ns/1ps
module nfe_classify
    import nfe_pkg::*;
(
    input  logic [7:0] st,
    output result_e    code,
    output logic       retry
);
    always_comb begin
        retry = 1'b0;
        if (st[5] && st[4])
            code = RES_BADSEQ;
        else if (st[1])
            code = RES_PROTECT;
        else if (st[3])
            code = RES_LOWVOLT;
        else begin
            code  = RES_FAIL;
            retry = st[5];
        end
    end
endmodule

// File: rtl/nfe_erase_ctrl.sv
`timescale 1ns/1ps
module nfe_erase_ctrl
    import nfe_pkg::*;
#(
    parameter int AW         = 20,
    parameter int DEVS       = 2,
    parameter int READY_TO   = 16,
    parameter int ERASE_MULT = 20,
    parameter int MAX_RETRY  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               erase_req,
    input  logic [AW-1:0]      blk_addr,
    input  logic               rd_req,
    input  logic               resume,
    input  logic               suspend_en,
    output logic               busy,
    output logic               done,
    output logic [2:0]         result,
    output logic               suspended,
    output logic [AW-1:0]      fl_addr,
    output logic [DEVS*8-1:0]  fl_wdata,
    output logic               fl_we,
    output logic               fl_re,
    input  logic [DEVS*8-1:0]  fl_rdata
);
    localparam int DW = DEVS * 8;
    localparam int RW = $clog2(MAX_RETRY + 2);

    typedef struct packed {
        state_e          st;
        logic [RW-1:0]   tries;
        logic            no_susp;
        logic [AW-1:0]   addr;
        logic [7:0]      stat;
        result_e         res;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: S_IDLE, tries: '0, no_susp: 1'b0,
                                 addr: '0, stat: 8'h00, res: RES_OK};

    ctl_t       d, q;
    logic [7:0] merged;
    logic       all_rdy;
    logic       tmr_exp;
    logic       tmr_run;
    result_e    cls_code;
    logic       cls_retry;
    logic [7:0] cmd;

    nfe_stat_merge #(.DEVS(DEVS)) u_merge (
        .raw       (fl_rdata),
        .merged    (merged),
        .all_ready (all_rdy)
    );

    nfe_classify u_cls (
        .st    (q.stat),
        .code  (cls_code),
        .retry (cls_retry)
    );

    assign tmr_run = (q.st == S_RDY_POLL) || (q.st == S_ERS_POLL) || (q.st == S_SUS_POLL);

    nfe_poll_timer #(.SHORT_LIM(READY_TO), .MULT(ERASE_MULT)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (tmr_run),
        .use_long (q.st == S_ERS_POLL),
        .expired  (tmr_exp)
    );

    always_comb begin
        d = q;
        case (q.st)
            S_IDLE: if (erase_req) begin
                d.st      = S_RDY_CMD;
                d.addr    = blk_addr;
                d.tries   = '0;
                d.no_susp = 1'b0;
            end
            S_RDY_CMD:  d.st = S_RDY_POLL;
            S_RDY_POLL: begin
                if (all_rdy)      d.st = S_CLR;
                else if (tmr_exp) begin d.res = RES_TIMEOUT; d.st = S_DONE; end
            end
            S_CLR:      d.st = S_SETUP;
            S_SETUP:    d.st = S_CONFIRM;
            S_CONFIRM:  d.st = S_ERS_POLL;
            S_ERS_POLL: begin
                if (all_rdy)      d.st = S_FIN_STAT;
                else if (tmr_exp) d.st = S_TO_STAT;
                else if (rd_req && suspend_en && !q.no_susp) d.st = S_SUS_CMD;
            end
            S_TO_STAT:  begin d.res = RES_TIMEOUT; d.st = S_DONE; end
            S_SUS_CMD:  d.st = S_SUS_STAT;
            S_SUS_STAT: d.st = S_SUS_POLL;
            S_SUS_POLL: begin
                if (all_rdy)      d.st = S_SUSPENDED;
                else if (tmr_exp) begin d.no_susp = 1'b1; d.st = S_RES_CMD; end
            end
            S_SUSPENDED: if (resume) d.st = S_RES_CMD;
            S_RES_CMD:  d.st = S_RES_STAT;
            S_RES_STAT: d.st = S_ERS_POLL;
            S_FIN_STAT: d.st = S_FIN_READ;
            S_FIN_READ: begin
                d.stat = merged;
                if (|(merged & ERR_MASK)) d.st = S_ERR_CLR;
                else begin d.res = RES_OK; d.st = S_DONE; end
            end
            S_ERR_CLR:  d.st = S_ERR_STAT;
            S_ERR_STAT: begin
                if (cls_retry && (q.tries < RW'(MAX_RETRY))) begin
                    d.tries = q.tries + 1'b1;
                    d.st    = S_RDY_CMD;
                end else begin
                    d.res = cls_code;
                    d.st  = S_DONE;
                end
            end
            S_DONE:     d.st = S_IDLE;
            default:    d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    always_comb begin
        fl_we = 1'b0;
        fl_re = 1'b0;
        cmd   = 8'h00;
        case (q.st)
            S_RDY_CMD, S_SUS_STAT, S_RES_STAT, S_FIN_STAT, S_ERR_STAT, S_TO_STAT:
                begin fl_we = 1'b1; cmd = OP_STATUS; end
            S_CLR, S_ERR_CLR:       begin fl_we = 1'b1; cmd = OP_CLEAR; end
            S_SETUP:                begin fl_we = 1'b1; cmd = OP_ERASE; end
            S_CONFIRM, S_RES_CMD:   begin fl_we = 1'b1; cmd = OP_GO;    end
            S_SUS_CMD:              begin fl_we = 1'b1; cmd = OP_PAUSE; end
            S_RDY_POLL, S_ERS_POLL, S_SUS_POLL, S_FIN_READ: fl_re = 1'b1;
            default: ;
        endcase
    end

    assign fl_wdata  = {DEVS{cmd}};
    assign fl_addr   = q.addr;
    assign busy      = (q.st != S_IDLE);
    assign done      = (q.st == S_DONE);
    assign suspended = (q.st == S_SUSPENDED);
    assign result    = q.res;
endmodule

// File: rtl/nfe_erase_ctrl_chk.sv
`timescale 1ns/1ps
module nfe_erase_ctrl_chk #(
    parameter int AW         = 20,
    parameter int DEVS       = 2,
    parameter int LONG_LIMIT = 320
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [2:0]        result,
    input logic              suspended,
    input logic              suspend_en,
    input logic [AW-1:0]     fl_addr,
    input logic [DEVS*8-1:0] fl_wdata,
    input logic              fl_we,
    input logic              fl_re
);
    int unsigned rd_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_run_q <= 0;
        else if (fl_re) rd_run_q <= rd_run_q + 1;
        else            rd_run_q <= 0;
    end

    // R1
    first_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (fl_we && fl_wdata[7:0] == 8'h70));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fl_addr));

    // R2
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_we && fl_re));

    // R3
    read_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_re |-> (rd_run_q <= LONG_LIMIT));

    // R6
    result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result <= 3'd5));

    // R8
    susp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> (!fl_we && !fl_re && busy));

    // R10
    susp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended) |-> suspend_en);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

bind nfe_erase_ctrl nfe_erase_ctrl_chk #(
    .AW(AW), .DEVS(DEVS), .LONG_LIMIT(READY_TO * ERASE_MULT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .result(result),
    .suspended(suspended), .suspend_en(suspend_en), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re)
);

// File: tb/nfe_erase_ctrl_test.sv
`timescale 1ns/1ps
module nfe_erase_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        erase_req = 1'b0;
    logic [19:0] blk_addr = '0;
    logic        rd_req = 1'b0;
    logic        resume = 1'b0;
    logic        suspend_en = 1'b0;
    logic        busy, done, suspended, fl_we, fl_re;
    logic [2:0]  result;
    logic [19:0] fl_addr;
    logic [15:0] fl_wdata;
    logic [15:0] fl_rdata;

    always #5 clk = ~clk;

    nfe_erase_ctrl uut (
        .clk(clk), .rst_n(rst_n), .erase_req(erase_req), .blk_addr(blk_addr),
        .rd_req(rd_req), .resume(resume), .suspend_en(suspend_en),
        .busy(busy), .done(done), .result(result), .suspended(suspended),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R2";
    logic [19:0] cur_blk = '0;
    logic [7:0]  exp_q[$];
    bit    sus_seen = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // flash model configuration (bench-driven)
    bit   mdl_clr = 1'b0;
    bit   hang = 1'b0, ign_susp = 1'b0, idle_nr = 1'b0;
    int   erase_len = 20;
    int   fail_cfg = 0;
    logic [7:0] fe0 = 8'h00, fe1 = 8'h00;

    // flash model state
    bit   running = 1'b0, susp = 1'b0, susp_pend = 1'b0, armed = 1'b0;
    int   busy_cnt = 0, ack_cnt = 0, fail_left = 0;
    logic [7:0] err0 = 8'h00, err1 = 8'h00;
    logic rdy_bit;

    assign rdy_bit  = !idle_nr && (!running || susp);
    assign fl_rdata = {rdy_bit, err1[6:0], rdy_bit, err0[6:0]};

    always @(posedge clk) begin
        if (mdl_clr) begin
            running <= 1'b0; susp <= 1'b0; susp_pend <= 1'b0; armed <= 1'b0;
            err0 <= 8'h00; err1 <= 8'h00; fail_left <= fail_cfg;
        end else begin
            if (running && !susp && !hang) begin
                if (busy_cnt <= 1) begin
                    running <= 1'b0;
                    if (fail_left > 0) begin
                        err0 <= fe0; err1 <= fe1; fail_left <= fail_left - 1;
                    end
                end else busy_cnt <= busy_cnt - 1;
            end
            if (susp_pend) begin
                if (ack_cnt <= 1) begin susp <= 1'b1; susp_pend <= 1'b0; end
                else ack_cnt <= ack_cnt - 1;
            end
            if (fl_we) begin
                case (fl_wdata[7:0])
                    8'h50: begin err0 <= 8'h00; err1 <= 8'h00; end
                    8'h20: armed <= 1'b1;
                    8'hD0: begin
                        if (armed) begin
                            running <= 1'b1; busy_cnt <= erase_len; armed <= 1'b0;
                        end else if (susp) susp <= 1'b0;
                    end
                    8'hB0: if (running && !ign_susp) begin susp_pend <= 1'b1; ack_cnt <= 3; end
                    default: ;
                endcase
            end
        end
    end

    // reference comparison of every bus write against the expected command stream
    always @(negedge clk) begin
        if (rst_n) begin
            if (suspended) sus_seen = 1'b1;
            if (fl_we) begin
                if (exp_q.size() == 0) chk(1'b0, cur_req, int'(fl_wdata), -1);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(fl_wdata == {e, e}, cur_req, int'(fl_wdata), int'({e, e}));
                    chk(fl_addr == cur_blk, "R2", int'(fl_addr), int'(cur_blk));
                end
            end
        end
    end

    task automatic push_attempt();
        exp_q.push_back(8'h70); exp_q.push_back(8'h50);
        exp_q.push_back(8'h20); exp_q.push_back(8'hD0);
    endtask

    task automatic push_err_tail();
        exp_q.push_back(8'h70); exp_q.push_back(8'h50); exp_q.push_back(8'h70);
    endtask

    task automatic model_reset();
        @(negedge clk); mdl_clr = 1'b1;
        @(negedge clk); mdl_clr = 1'b0;
        sus_seen = 1'b0;
    endtask

    task automatic start_erase(input logic [19:0] a);
        @(negedge clk);
        cur_blk = a; blk_addr = a; erase_req = 1'b1;
        @(negedge clk);
        erase_req = 1'b0; blk_addr = ~a;
    endtask

    task automatic finish_erase(input int exp_res, input string req);
        int n = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
        chk(done == 1'b1, req, int'(done), 1);
        chk(int'(result) == exp_res, req, int'(result), exp_res);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R11", int'({busy, done}), 0);
    endtask

    initial begin
        #(10 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        mdl_clr = 1'b1;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk({busy, done, suspended, fl_we, fl_re} == 5'b0, "R11",
            int'({busy, done, suspended, fl_we, fl_re}), 0);
        rst_n = 1'b1; mdl_clr = 1'b0;
        @(negedge clk);

        // R4 / R2: clean erase
        cur_req = "R4"; fail_cfg = 0; erase_len = 20; model_reset();
        push_attempt(); exp_q.push_back(8'h70);
        start_erase(20'h1A000); finish_erase(0, "R4");

        // R5 / R6: split lanes 0x02 | 0x08 -> protected
        cur_req = "R5"; fe0 = 8'h02; fe1 = 8'h08; fail_cfg = 1; model_reset();
        push_attempt(); push_err_tail();
        start_erase(20'h22000); finish_erase(3, "R5");

        // R6: 0x10 | 0x20 across lanes -> bad sequence, no retry
        cur_req = "R6"; fe0 = 8'h10; fe1 = 8'h20; fail_cfg = 1; model_reset();
        push_attempt(); push_err_tail();
        start_erase(20'h03000); finish_erase(2, "R6");

        // R6: low voltage
        fe0 = 8'h08; fe1 = 8'h00; fail_cfg = 1; model_reset();
        push_attempt(); push_err_tail();
        start_erase(20'h04000); finish_erase(4, "R6");

        // R6 / R7: 0x10 alone -> erase fail without retry
        fe0 = 8'h00; fe1 = 8'h10; fail_cfg = 1; model_reset();
        push_attempt(); push_err_tail();
        start_erase(20'h05000); finish_erase(5, "R6");

        // R7: one plain failure then success
        cur_req = "R7"; fe0 = 8'h20; fe1 = 8'h00; fail_cfg = 1; model_reset();
        push_attempt(); push_err_tail(); push_attempt(); exp_q.push_back(8'h70);
        start_erase(20'h06000); finish_erase(0, "R7");

        // R7: retries exhausted (1 + MAX_RETRY attempts)
        fail_cfg = 3; model_reset();
        for (int i = 0; i < 3; i++) begin push_attempt(); push_err_tail(); end
        start_erase(20'h07000); finish_erase(5, "R7");

        // R1: array never ready
        cur_req = "R1"; fail_cfg = 0; idle_nr = 1'b1; model_reset();
        exp_q.push_back(8'h70);
        start_erase(20'h08000); finish_erase(1, "R1");
        idle_nr = 1'b0;

        // R3: erase never completes
        cur_req = "R3"; hang = 1'b1; model_reset();
        push_attempt(); exp_q.push_back(8'h70);
        start_erase(20'h09000); finish_erase(1, "R3");
        hang = 1'b0;

        // R8: suspend and resume
        cur_req = "R8"; suspend_en = 1'b1; erase_len = 60; model_reset();
        push_attempt(); exp_q.push_back(8'hB0); exp_q.push_back(8'h70);
        exp_q.push_back(8'hD0); exp_q.push_back(8'h70); exp_q.push_back(8'h70);
        start_erase(20'h0A000);
        repeat (8) @(negedge clk);
        rd_req = 1'b1;
        begin
            int n = 0;
            while (!suspended && n < 200) begin @(negedge clk); n++; end
        end
        chk(suspended == 1'b1, "R8", int'(suspended), 1);
        repeat (4) begin
            @(negedge clk);
            chk(!fl_we && !fl_re && suspended, "R8", int'({fl_we, fl_re, suspended}), 1);
        end
        rd_req = 1'b0; resume = 1'b1;
        @(negedge clk); resume = 1'b0;
        finish_erase(0, "R8");

        // R9: suspend never acknowledged, rd_req held throughout
        cur_req = "R9"; ign_susp = 1'b1; erase_len = 100; model_reset();
        push_attempt(); exp_q.push_back(8'hB0); exp_q.push_back(8'h70);
        exp_q.push_back(8'hD0); exp_q.push_back(8'h70); exp_q.push_back(8'h70);
        start_erase(20'h0B000);
        repeat (8) @(negedge clk);
        rd_req = 1'b1;
        finish_erase(0, "R9");
        rd_req = 1'b0;
        chk(sus_seen == 1'b0, "R9", int'(sus_seen), 0);
        ign_susp = 1'b0;

        // R10: suspend disabled, read request ignored
        cur_req = "R10"; suspend_en = 1'b0; erase_len = 40; model_reset();
        push_attempt(); exp_q.push_back(8'h70);
        rd_req = 1'b1;
        start_erase(20'h0C000);
        finish_erase(0, "R10");
        rd_req = 1'b0;
        chk(sus_seen == 1'b0, "R10", int'(sus_seen), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule